// File: doc/BRIEF.md
# Paged external data-memory bus sequencer

This block takes single-byte data-memory read and write requests from a CPU core and runs them as cycles on an external bus. The bus has a one-byte address port that carries the upper address byte while ALE is high and the lower address byte for the rest of the access. A separate data port carries write data out and read data in. The sequencer keeps the upper byte of the last access. When a new access uses the same upper byte, it runs a short page-hit cycle that skips the ALE phase. Any other access runs a longer page-miss cycle.

A 3-bit stretch value is given with each request and lengthens the access for slow devices. The first stretch cycle spreads its four clocks over address setup, strobe width and hold. Each further stretch cycle only lengthens the strobe. The core pulses `req_i` for one clock while the block is idle. A one-clock `done_o` marks the last clock of the access. `rdata_o` is valid from that clock on.

Top module: `ext_page_seq`

## Requirements
- R1: With stretch 0, a page-hit access takes 2 clocks from acceptance to `done_o` inclusive: 1 strobe clock and 1 hold clock, with no ALE and no setup clock.
- R2: With stretch 0, a page-miss access takes 4 clocks: 1 ALE clock, 1 setup clock, 1 strobe clock and 1 hold clock. ALE is high only in the ALE clock and never together with a strobe.
- R3: An access is a hit only if an earlier access exists since reset and its upper address byte equals the new upper byte. The first access after reset is a miss, and any change of the upper byte gives a miss.
- R4: Stretch 1 adds exactly 4 clocks: 1 extra setup clock, 2 extra strobe clocks (3 in total) and 1 extra hold clock (2 in total).
- R5: Stretch n from 2 to 7 gives a strobe of 4n-1 clocks and 2 hold clocks. The total is the stretch-0 length plus 4n.
- R6: For a read, the data port is sampled at the clock edge that ends the strobe. That value is on `rdata_o` when `done_o` is high.
- R7: A read pulls only `rd_no` low and a write pulls only `wr_no` low, during the strobe clocks. For a write, `bus_data_oe_o` is high with the request's write data on `bus_data_o` for every strobe and hold clock, and low at all other times.
- R8: `done_o` is high for exactly one clock per access. A `req_i` pulse while an access is in progress is ignored: it does not change that access's length and does not update the stored page.
- R9: In reset, `rd_no` and `wr_no` are high, and `ale_o`, `done_o` and `bus_data_oe_o` are low.
- R10: `bus_addr_o` carries the upper address byte in the ALE clock and the lower address byte in every other clock of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request pulse, taken only while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Data-memory byte address |
| wdata_i | input | 8 | Write data |
| stretch_i | input | 3 | Stretch count for this access |
| done_o | output | 1 | One-clock pulse in the last clock of an access |
| rdata_o | output | 8 | Read data captured at the end of the strobe |
| ale_o | output | 1 | Address latch enable, high in the page-miss address clock |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| bus_addr_o | output | 8 | Multiplexed upper/lower address byte |
| bus_data_o | output | 8 | Write data toward the bus |
| bus_data_oe_o | output | 1 | Drive enable for `bus_data_o` |
| bus_data_i | input | 8 | Read data from the bus |

## Verification
If the stored page byte or its valid flag is wrong, the next access shows it at once. An ALE clock appears or goes missing, and the access is 2 clocks too long or too short. The bench's external latch then also returns read data for the wrong address. A wrong phase counter shows in the first access that uses that stretch value, as a wrong count of setup, strobe or hold clocks before `done_o`. A request wrongly accepted while busy changes the page. The following access, which the bench expects to hit the page, then runs 2 clocks too long.

// File: rtl/ext_page_seq_pkg.sv
package ext_page_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE    = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;
endpackage

// File: rtl/ext_page_track.sv
module ext_page_track #(
  parameter int HI_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [HI_W-1:0] hi_i,
  output logic            hit_o
);
  logic            valid_q;
  logic [HI_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      page_q  <= hi_i;
    end
  end

  assign hit_o = valid_q && (hi_i == page_q);

  assert_page_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (page_q == $past(hi_i)) && valid_q);
endmodule

// File: rtl/ext_phase_len.sv
module ext_phase_len #(
  parameter int STRETCH_W = 3,
  localparam int CNT_W = STRETCH_W + 2
) (
  input  logic [STRETCH_W-1:0] stretch_i,
  input  logic                 miss_i,
  output logic                 nz_o,
  output logic                 setup_last_o,
  output logic [CNT_W-1:0]     strobe_last_o
);
  // strobe length: 1 clock at stretch 0, 4n-1 clocks otherwise
  assign nz_o          = |stretch_i;
  assign setup_last_o  = miss_i && nz_o;
  assign strobe_last_o = nz_o ? ({stretch_i, 2'b00} - CNT_W'(2)) : '0;
endmodule

// File: rtl/ext_bus_fsm.sv
module ext_bus_fsm
  import ext_page_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STRETCH_W = 3,
  localparam int CNT_W = STRETCH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hit_i,
  input  logic              nz_i,
  input  logic              setup_last_i,
  input  logic [CNT_W-1:0]  strobe_last_i,
  output logic              accept_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_data_i
);
  phase_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              we_q, nz_q, setup_last_q;
  logic [CNT_W-1:0]  strobe_last_q;
  logic [DATA_W-1:0] hi_q, lo_q, wdata_q, rdata_q;
  logic              last;

  assign accept_o = (state_q == PH_IDLE) && req_i;
  assign last     = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= PH_IDLE;
      cnt_q         <= '0;
      we_q          <= 1'b0;
      nz_q          <= 1'b0;
      setup_last_q  <= 1'b0;
      strobe_last_q <= '0;
      hi_q          <= '0;
      lo_q          <= '0;
      wdata_q       <= '0;
      rdata_q       <= '0;
    end else begin
      unique case (state_q)
        PH_IDLE: if (req_i) begin
          we_q          <= we_i;
          nz_q          <= nz_i;
          setup_last_q  <= setup_last_i;
          strobe_last_q <= strobe_last_i;
          hi_q          <= hi_i;
          lo_q          <= lo_i;
          wdata_q       <= wdata_i;
          if (!hit_i) begin
            state_q <= PH_ALE;
            cnt_q   <= '0;
          end else if (nz_i) begin
            state_q <= PH_SETUP;
            cnt_q   <= '0;
          end else begin
            state_q <= PH_STROBE;
            cnt_q   <= strobe_last_i;
          end
        end
        PH_ALE: begin
          state_q <= PH_SETUP;
          cnt_q   <= CNT_W'(setup_last_q);
        end
        PH_SETUP: begin
          if (last) begin
            state_q <= PH_STROBE;
            cnt_q   <= strobe_last_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (last) begin
            state_q <= PH_HOLD;
            cnt_q   <= CNT_W'(nz_q);
            if (!we_q) rdata_q <= bus_data_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (last) state_q <= PH_IDLE;
          else      cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  assign done_o        = (state_q == PH_HOLD) && last;
  assign rdata_o       = rdata_q;
  assign ale_o         = (state_q == PH_ALE);
  assign rd_no         = !((state_q == PH_STROBE) && !we_q);
  assign wr_no         = !((state_q == PH_STROBE) && we_q);
  assign bus_addr_o    = (state_q == PH_ALE || state_q == PH_IDLE) ? hi_q : lo_q;
  assign bus_data_o    = wdata_q;
  assign bus_data_oe_o = we_q && (state_q == PH_STROBE || state_q == PH_HOLD);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PH_IDLE) |=> $stable(lo_q) && $stable(hi_q));
  assert_ale_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o && rd_no && wr_no);
  assert_rdata_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && last) |=> rdata_o == $past(bus_data_i));
  assert_oe_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_data_oe_o && wr_no) |-> $past(bus_data_oe_o));
endmodule

// File: rtl/ext_page_seq.sv
module ext_page_seq #(
  parameter int DATA_W    = 8,
  parameter int STRETCH_W = 3,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int CNT_W  = STRETCH_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [STRETCH_W-1:0] stretch_i,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 ale_o,
  output logic                 rd_no,
  output logic                 wr_no,
  output logic [DATA_W-1:0]    bus_addr_o,
  output logic [DATA_W-1:0]    bus_data_o,
  output logic                 bus_data_oe_o,
  input  logic [DATA_W-1:0]    bus_data_i
);
  logic             accept, hit, nz, setup_last;
  logic [CNT_W-1:0] strobe_last;

  ext_page_track #(.HI_W(DATA_W)) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .hi_i   (addr_i[ADDR_W-1:DATA_W]),
    .hit_o  (hit)
  );

  ext_phase_len #(.STRETCH_W(STRETCH_W)) u_len (
    .stretch_i     (stretch_i),
    .miss_i        (!hit),
    .nz_o          (nz),
    .setup_last_o  (setup_last),
    .strobe_last_o (strobe_last)
  );

  ext_bus_fsm #(.DATA_W(DATA_W), .STRETCH_W(STRETCH_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .we_i          (we_i),
    .hi_i          (addr_i[ADDR_W-1:DATA_W]),
    .lo_i          (addr_i[DATA_W-1:0]),
    .wdata_i       (wdata_i),
    .hit_i         (hit),
    .nz_i          (nz),
    .setup_last_i  (setup_last),
    .strobe_last_i (strobe_last),
    .accept_o      (accept),
    .done_o        (done_o),
    .rdata_o       (rdata_o),
    .ale_o         (ale_o),
    .rd_no         (rd_no),
    .wr_no         (wr_no),
    .bus_addr_o    (bus_addr_o),
    .bus_data_o    (bus_data_o),
    .bus_data_oe_o (bus_data_oe_o),
    .bus_data_i    (bus_data_i)
  );

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no) && !(ale_o && bus_data_oe_o));
endmodule

// File: tb/sim_ext_page_seq.sv
module sim_ext_page_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [2:0] stretch = '0;
  logic done, ale, rd_n, wr_n, oe;
  logic [7:0] rdata, baddr, bdout, bdin, ext_hi;

  int total = 0, bad = 0;
  bit pv = 0;
  logic [7:0] pg = '0;

  always #(CLK_P/2) clk = ~clk;

  ext_page_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .stretch_i(stretch), .done_o(done), .rdata_o(rdata),
    .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n), .bus_addr_o(baddr),
    .bus_data_o(bdout), .bus_data_oe_o(oe), .bus_data_i(bdin)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // external device: upper byte latched by ALE, lower byte live on the port
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ext_hi <= '0;
    else if (ale) ext_hi <= baddr;
  assign bdin = rd_n ? 8'h00 : mem_f({ext_hi, baddr});

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d,
                        input int s, input bit poke);
    bit miss;
    int e_tot, e_str, e_hold, e_setup;
    int n = 0, n_ale = 0, n_str = 0, n_hold = 0, n_setup = 0, n_oe = 0;
    int bad_addr = 0, bad_wd = 0, bad_strb = 0;
    bit seen_str = 0;
    string t_tot, t_str;
    logic [7:0] rd_seen = '0;
    miss    = !(pv && a[15:8] == pg);
    e_tot   = (miss ? 4 : 2) + 4 * s;
    e_str   = (s == 0) ? 1 : 4 * s - 1;
    e_hold  = (s == 0) ? 1 : 2;
    e_setup = (miss ? 1 : 0) + (s != 0 ? 1 : 0);
    t_tot   = (s != 0) ? "R5" : (miss ? "R2" : "R1");
    t_str   = (s == 1) ? "R4" : ((s == 0) ? "R1" : "R5");
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d; stretch = 3'(s);
    @(negedge clk);
    req = 0;
    pv = 1; pg = a[15:8];
    forever begin
      n++;
      if (n > 1) @(negedge clk);
      if (poke && n == 2) req = 0;
      if (ale) begin
        n_ale++;
        if (baddr != a[15:8]) bad_addr++;
      end else if (baddr != a[7:0]) bad_addr++;
      if (!rd_n || !wr_n) begin
        n_str++; seen_str = 1;
        if (w ? !rd_n : !wr_n) bad_strb++;
      end else if (seen_str) n_hold++;
      else if (!ale) n_setup++;
      if (oe) begin
        n_oe++;
        if (bdout != d) bad_wd++;
      end
      if (done) begin
        rd_seen = rdata;
        break;
      end
      if (n > 64) break;
      if (poke && n == 1) begin
        req = 1; we = ~w; addr = a ^ 16'hA500; stretch = 3'd7;
      end
    end
    chk(n == e_tot, t_tot, n, e_tot);
    chk(n_ale == (miss ? 1 : 0), miss ? "R2" : "R3", n_ale, miss ? 1 : 0);
    chk(n_setup == e_setup, "R4", n_setup, e_setup);
    chk(n_str == e_str, t_str, n_str, e_str);
    chk(n_hold == e_hold, "R4", n_hold, e_hold);
    chk(bad_addr == 0, "R10", bad_addr, 0);
    chk(bad_strb == 0, "R7", bad_strb, 0);
    if (w) begin
      chk(n_oe == e_str + e_hold, "R7", n_oe, e_str + e_hold);
      chk(bad_wd == 0, "R7", bad_wd, 0);
    end else begin
      chk(n_oe == 0, "R7", n_oe, 0);
      chk(rd_seen == mem_f(a), "R6", rd_seen, mem_f(a));
    end
    @(negedge clk);
    chk(done == 0, "R8", done, 0);
  endtask

  initial begin
    repeat (CLK_P * 15000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r;
    r = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({rd_n, wr_n, ale, done, oe} == 5'b11000, "R9",
        {rd_n, wr_n, ale, done, oe}, 5'b11000);
    rst_n = 1;
    access(0, 16'h1234, 8'h00, 0, 0);  // R3 first access after reset is a miss
    access(0, 16'h1277, 8'h00, 0, 0);  // R1 hit
    access(1, 16'h1201, 8'hC3, 0, 0);  // R7 write hit
    access(1, 16'h3402, 8'h3C, 0, 0);  // R3 page change
    access(0, 16'h5610, 8'h00, 1, 0);  // R4 miss stretch 1
    access(0, 16'h5611, 8'h00, 1, 0);  // R4 hit stretch 1
    access(1, 16'h5612, 8'h99, 2, 0);  // R5
    access(0, 16'h7813, 8'h00, 3, 0);  // R5
    access(1, 16'h7814, 8'h81, 7, 0);  // R5 max stretch
    access(0, 16'h7815, 8'h00, 0, 1);  // R8 request while busy
    access(0, 16'h7816, 8'h00, 0, 0);  // R8 page untouched by ignored request
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      int sel;
      sel = int'($urandom % 4);
      a = 16'($urandom);
      if (sel == 0) a[15:8] = 8'h12;
      else if (sel == 1) a[15:8] = 8'h34;
      else if (sel == 2) a[15:8] = pg;
      access(1'($urandom), a, 8'($urandom), int'($urandom % 8), (i % 17) == 5);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule